// File: doc/BRIEF.md
# I2C Target Receive DMA Engine

This block sits behind the bit-level front end of an I2C port and handles writes that an external bus controller addresses to the local target address. The front end reports each transfer as a short event stream: a start event carrying the 7-bit address and direction, one valid pulse per data byte, and a stop event. When a start matches the programmed address, the direction is write, and both target mode and receive DMA are enabled, the engine loads its counters from the configured buffer base and length. It then streams the bytes into memory through a 32-bit word-write port with byte enables.

At a normal stop the engine raises completion status. Software clears that status with a write-one-to-clear strobe. Writing the done bit wipes the completion group in one go. The overflow flag sits above that group and is kept until it is written directly. A single interrupt line is shared with the controller-mode side of the port. Whichever source holds the line keeps it until its own status clears. The line then drops for one cycle and is handed to the other source if that source is waiting.

Top module: `i2c_tgt_rx_dma`

## Requirements
- R1: A matching start loads the counters one cycle later. A matching start has an address equal to `cfgTgtAddr`, `evRead`=0, and both `cfgTgtEn` and `cfgRxDmaEn` set. On load, `rxLen` becomes 0, `dmaAddr` becomes `cfgBufBase` with bits [1:0] forced to zero, and `dmaRemain` becomes the smaller of `cfgBufLen` and 4096.
- R2: Every accepted byte adds one to `dmaAddr` and `rxLen` and subtracts one from `dmaRemain`. The new values are visible in the cycle after the byte, so `rxLen` tracks the transfer while it runs.
- R3: Bytes are packed little-endian. A byte whose address has bits [1:0] equal to k goes to `memData[8k+7:8k]`. The cycle after the byte that fills lane 3, `memWe` pulses with `memBe`=4'b1111 and `memAddr` set to the word-aligned address.
- R4: At a stop, if the last word is partly filled, `memWe` pulses in the cycle after the stop. `memBe` is 4'b0001, 4'b0011 or 4'b0111 for one, two or three filled lanes, and unfilled lanes carry zero. No write occurs when the last word is empty.
- R5: A stop during an active receive sets four status bits together in the cycle after the stop: bit0 address-hit, bit1 stop-seen, bit2 receive-direction, bit3 done.
- R6: A byte that arrives with `dmaRemain`=0 is dropped. Nothing is written and no counter moves. Status bit4 (overflow) is set in the cycle after that byte, and the completion bits are still set at the stop.
- R7: `clrWe` with `clrData` clears each status bit whose `clrData` bit is 1. If `clrData` bit3 is 1, bits 3..0 are all cleared. Bit4 is cleared only by `clrData` bit4.
- R8: A start that does not match leaves the block idle until the next matching start. This covers a different address, `evRead`=1, or either enable low. The bytes and stop that follow cause no memory write and no change to `rxLen`, `dmaAddr`, `dmaRemain` or `status`.
- R9: The target request is the OR of `status & cfgIrqEn`. With the line free, `irqOut` rises one cycle after the request appears. It falls one cycle after the request is removed by a clear write.
- R10: While one source holds `irqOut`, a request from the other source is held pending. When the holder's request ends, `irqOut` is low for exactly one cycle and then rises again for the pending source. This applies in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTgtAddr | input | 7 | Local target address |
| cfgTgtEn | input | 1 | Target mode enable |
| cfgRxDmaEn | input | 1 | Receive DMA enable |
| cfgBufBase | input | AW (16) | Buffer base byte address |
| cfgBufLen | input | LEN_W (13) | Buffer length in bytes |
| cfgIrqEn | input | 5 | Per-bit interrupt enable for status |
| evStart | input | 1 | Start event with address byte |
| evAddr | input | 7 | Address carried by the start event |
| evRead | input | 1 | Direction bit of the start event (1 = read) |
| evByte | input | 1 | Data byte valid |
| evData | input | 8 | Data byte |
| evStop | input | 1 | Normal stop event |
| clrWe | input | 1 | Status clear strobe |
| clrData | input | 5 | Status bits to clear |
| hostIrqReq | input | 1 | Controller-mode interrupt request |
| memWe | output | 1 | Memory word write strobe |
| memAddr | output | AW (16) | Word-aligned byte address |
| memData | output | 32 | Write data |
| memBe | output | 4 | Byte enables |
| rxLen | output | LEN_W (13) | Bytes received in this transfer |
| dmaAddr | output | AW (16) | Current byte address counter |
| dmaRemain | output | LEN_W (13) | Remaining buffer bytes |
| status | output | 5 | Interrupt status |
| irqOut | output | 1 | Shared interrupt line |

## Verification
Counters, status, memory writes and the overflow flag are all due one cycle after the event that causes them. The interrupt line follows its request one cycle later again, so it rises two cycles after a stop and falls two cycles after a clear strobe. The bench drives every event at a falling edge and samples at the next falling edge, which is exactly one rising edge later; for the line it waits one more falling edge. Memory writes are predicted into a queue before stimulus, and a monitor compares each write strobe against the head of the queue on the falling edge where it appears.

// File: rtl/i2c_tgt_rx_dma_pkg.sv
package i2c_tgt_rx_dma_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic take;
    logic flush;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_TGT  = 2'd2
  } lineOwner_t;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rxState_t;

  // status bit positions
  localparam int ST_HIT  = 0;
  localparam int ST_STOP = 1;
  localparam int ST_RX   = 2;
  localparam int ST_DONE = 3;
  localparam int ST_OVF  = 4;
  localparam int ST_W    = 5;

endpackage

// File: rtl/i2c_tgt_rx_dma_ctrl.sv
module i2c_tgt_rx_dma_ctrl
  import i2c_tgt_rx_dma_pkg::*;
#(
  parameter int ADDR7_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR7_W-1:0] cfgTgtAddr,
  input  logic               cfgTgtEn,
  input  logic               cfgRxDmaEn,
  input  logic               evStart,
  input  logic [ADDR7_W-1:0] evAddr,
  input  logic               evRead,
  input  logic               evByte,
  input  logic               evStop,
  input  logic               clrWe,
  input  logic [ST_W-1:0]    clrData,
  input  logic               remainZero,
  output dpStrobe_t          strb,
  output logic [ST_W-1:0]    status
);

  rxState_t        state;
  logic            matchHit;
  logic            ovfEv;
  logic            doneEv;
  logic [ST_W-1:0] stNext;

  assign matchHit = evStart && (evAddr == cfgTgtAddr) && !evRead && cfgTgtEn && cfgRxDmaEn;
  assign ovfEv    = (state == RX_BUSY) && !evStart && evByte && remainZero;
  assign doneEv   = (state == RX_BUSY) && !evStart && evStop;

  always_comb begin
    strb.load  = matchHit;
    strb.take  = (state == RX_BUSY) && !evStart && evByte && !remainZero;
    strb.flush = doneEv;
  end

  // clear first, then set, so a fresh event is never lost
  always_comb begin
    stNext = status;
    if (clrWe) begin
      stNext = stNext & ~clrData;
      if (clrData[ST_DONE]) stNext[ST_DONE:0] = '0;
    end
    if (ovfEv)  stNext[ST_OVF] = 1'b1;
    if (doneEv) stNext[ST_DONE:0] = '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      status <= '0;
    end else begin
      status <= stNext;
      if (matchHit)       state <= RX_BUSY;
      else if (evStart)   state <= RX_IDLE;
      else if (evStop)    state <= RX_IDLE;
    end
  end

  AST_STOP_SETS_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_BUSY && evStop && !evStart) |=> (status[ST_DONE:0] == 4'hF)); // R5

  AST_MISMATCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (evStart && !matchHit && !clrWe) |=> $stable(status)); // R8

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_BUSY && evByte && !evStart && remainZero) |=> status[ST_OVF]); // R6

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && clrData[ST_DONE] && !evStop && !evByte) |=> (status[ST_DONE:0] == '0)); // R7

endmodule

// File: rtl/i2c_tgt_rx_dma_dp.sv
module i2c_tgt_rx_dma_dp
  import i2c_tgt_rx_dma_pkg::*;
#(
  parameter int AW      = 16,
  parameter int BUF_MAX = 4096,
  parameter int LEN_W   = $clog2(BUF_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [AW-1:0]    bufBase,
  input  logic [LEN_W-1:0] bufLen,
  input  logic [7:0]       rxByte,
  output logic             remainZero,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [31:0]      memData,
  output logic [3:0]       memBe,
  output logic [LEN_W-1:0] rxLen,
  output logic [AW-1:0]    dmaAddr,
  output logic [LEN_W-1:0] dmaRemain
);

  localparam int LANES = 4;
  localparam int LANE_W = $clog2(LANES);

  logic [31:0]       wordBuf;
  logic [31:0]       mergedWord;
  logic [LANE_W-1:0] lane;
  logic [LANES-1:0]  partialBe;
  logic [LEN_W-1:0]  clampLen;
  logic [AW-1:0]     wordAddr;

  assign lane       = dmaAddr[LANE_W-1:0];
  assign wordAddr   = {dmaAddr[AW-1:LANE_W], {LANE_W{1'b0}}};
  assign remainZero = (dmaRemain == '0);
  assign clampLen   = (bufLen > LEN_W'(BUF_MAX)) ? LEN_W'(BUF_MAX) : bufLen;

  for (genvar g = 0; g < LANES; g++) begin : g_be
    assign partialBe[g] = (lane > LANE_W'(g));
  end

  always_comb begin
    mergedWord = wordBuf;
    mergedWord[lane*8 +: 8] = rxByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordBuf   <= '0;
      rxLen     <= '0;
      dmaAddr   <= '0;
      dmaRemain <= '0;
      memWe     <= 1'b0;
      memAddr   <= '0;
      memData   <= '0;
      memBe     <= '0;
    end else begin
      memWe <= 1'b0;
      if (strb.load) begin
        wordBuf   <= '0;
        rxLen     <= '0;
        dmaAddr   <= {bufBase[AW-1:LANE_W], {LANE_W{1'b0}}};
        dmaRemain <= clampLen;
      end else if (strb.take) begin
        rxLen     <= rxLen + 1'b1;
        dmaAddr   <= dmaAddr + 1'b1;
        dmaRemain <= dmaRemain - 1'b1;
        if (lane == LANE_W'(LANES - 1)) begin
          memWe   <= 1'b1;
          memAddr <= wordAddr;
          memData <= mergedWord;
          memBe   <= '1;
          wordBuf <= '0;
        end else begin
          wordBuf <= mergedWord;
        end
      end else if (strb.flush) begin
        if (lane != '0) begin
          memWe   <= 1'b1;
          memAddr <= wordAddr;
          memData <= wordBuf;
          memBe   <= partialBe;
        end
        wordBuf <= '0;
      end
    end
  end

  AST_LOAD_ZERO_LEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (rxLen == '0)); // R1

  AST_TAKE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && !strb.load) |=> (dmaRemain == $past(dmaRemain) - 1'b1)
                                 && (rxLen == $past(rxLen) + 1'b1)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> !remainZero); // R6

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[LANE_W-1:0] == '0)); // R3

endmodule

// File: rtl/i2c_tgt_rx_dma_irq.sv
module i2c_tgt_rx_dma_irq
  import i2c_tgt_rx_dma_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hostReq,
  input  logic tgtReq,
  output logic irqOut
);

  lineOwner_t owner;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner <= OWN_NONE;
    end else begin
      unique case (owner)
        OWN_NONE: begin
          if (hostReq)     owner <= OWN_HOST;
          else if (tgtReq) owner <= OWN_TGT;
        end
        OWN_HOST: if (!hostReq) owner <= OWN_NONE;
        OWN_TGT:  if (!tgtReq)  owner <= OWN_NONE;
        default:  owner <= OWN_NONE;
      endcase
    end
  end

  assign irqOut = (owner != OWN_NONE);

  AST_HOST_TO_TGT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_HOST) |=> (owner != OWN_TGT)); // R10

  AST_TGT_TO_HOST_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_TGT) |=> (owner != OWN_HOST)); // R10

  AST_TGT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_TGT && tgtReq) |=> irqOut); // R9

endmodule

// File: rtl/i2c_tgt_rx_dma.sv
module i2c_tgt_rx_dma
  import i2c_tgt_rx_dma_pkg::*;
#(
  parameter int AW      = 16,
  parameter int BUF_MAX = 4096,
  localparam int LEN_W  = $clog2(BUF_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [6:0]       cfgTgtAddr,
  input  logic             cfgTgtEn,
  input  logic             cfgRxDmaEn,
  input  logic [AW-1:0]    cfgBufBase,
  input  logic [LEN_W-1:0] cfgBufLen,
  input  logic [4:0]       cfgIrqEn,
  input  logic             evStart,
  input  logic [6:0]       evAddr,
  input  logic             evRead,
  input  logic             evByte,
  input  logic [7:0]       evData,
  input  logic             evStop,
  input  logic             clrWe,
  input  logic [4:0]       clrData,
  input  logic             hostIrqReq,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [31:0]      memData,
  output logic [3:0]       memBe,
  output logic [LEN_W-1:0] rxLen,
  output logic [AW-1:0]    dmaAddr,
  output logic [LEN_W-1:0] dmaRemain,
  output logic [4:0]       status,
  output logic             irqOut
);

  dpStrobe_t strb;
  logic      remainZero;
  logic      tgtReq;

  i2c_tgt_rx_dma_ctrl #(.ADDR7_W(7)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgTgtAddr(cfgTgtAddr), .cfgTgtEn(cfgTgtEn), .cfgRxDmaEn(cfgRxDmaEn),
    .evStart(evStart), .evAddr(evAddr), .evRead(evRead),
    .evByte(evByte), .evStop(evStop),
    .clrWe(clrWe), .clrData(clrData),
    .remainZero(remainZero), .strb(strb), .status(status)
  );

  i2c_tgt_rx_dma_dp #(.AW(AW), .BUF_MAX(BUF_MAX), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .bufBase(cfgBufBase), .bufLen(cfgBufLen), .rxByte(evData),
    .remainZero(remainZero),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .memBe(memBe),
    .rxLen(rxLen), .dmaAddr(dmaAddr), .dmaRemain(dmaRemain)
  );

  assign tgtReq = |(status & cfgIrqEn);

  i2c_tgt_rx_dma_irq u_irq (
    .clk(clk), .rstN(rstN),
    .hostReq(hostIrqReq), .tgtReq(tgtReq), .irqOut(irqOut)
  );

endmodule

// File: tb/i2c_tgt_rx_dma_tb.sv
module i2c_tgt_rx_dma_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LEN_W = 13;

  logic             clk = 1'b0;
  logic             rstN;
  logic [6:0]       cfgTgtAddr;
  logic             cfgTgtEn, cfgRxDmaEn;
  logic [AW-1:0]    cfgBufBase;
  logic [LEN_W-1:0] cfgBufLen;
  logic [4:0]       cfgIrqEn;
  logic             evStart, evRead, evByte, evStop;
  logic [6:0]       evAddr;
  logic [7:0]       evData;
  logic             clrWe;
  logic [4:0]       clrData;
  logic             hostIrqReq;
  logic             memWe;
  logic [AW-1:0]    memAddr;
  logic [31:0]      memData;
  logic [3:0]       memBe;
  logic [LEN_W-1:0] rxLen;
  logic [AW-1:0]    dmaAddr;
  logic [LEN_W-1:0] dmaRemain;
  logic [4:0]       status;
  logic             irqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tgt_rx_dma u_dut (.*);

  typedef struct packed {
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic [3:0]    be;
  } wr_t;

  wr_t expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushWr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    expQ.push_back({a, d, be});
  endtask

  // monitor: compare each memory write with the head of the queue
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R3/R4 unexpected write actual=%h/%h/%h expected=none", memAddr, memData, memBe);
      end else begin
        wr_t e;
        e = expQ.pop_front();
        check("R3/R4 write addr", 32'(memAddr), 32'(e.a));
        check("R3/R4 write data", memData, e.d);
        check("R3/R4 write be", 32'(memBe), 32'(e.be));
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic startXfer(input logic [6:0] a, input logic rd);
    @(negedge clk); evStart = 1; evAddr = a; evRead = rd;
    @(negedge clk); evStart = 0; evRead = 0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    @(negedge clk); evByte = 1; evData = d;
    @(negedge clk); evByte = 0;
  endtask

  task automatic stopXfer();
    @(negedge clk); evStop = 1;
    @(negedge clk); evStop = 0;
  endtask

  task automatic clearWrite(input logic [4:0] v);
    @(negedge clk); clrWe = 1; clrData = v;
    @(negedge clk); clrWe = 0; clrData = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; cfgTgtAddr = 7'h2A; cfgTgtEn = 1; cfgRxDmaEn = 1;
    cfgBufBase = 16'h0100; cfgBufLen = 13'd16; cfgIrqEn = 5'h1F;
    evStart = 0; evAddr = '0; evRead = 0; evByte = 0; evData = '0; evStop = 0;
    clrWe = 0; clrData = '0; hostIrqReq = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
    check("reset status", 32'(status), 32'h0);
    check("reset irq", 32'(irqOut), 32'h0);
    check("reset rxLen", 32'(rxLen), 32'h0);
    check("reset memWe", 32'(memWe), 32'h0);

    // basic receive of six bytes
    startXfer(7'h2A, 0);
    check("R1 rxLen zero", 32'(rxLen), 0);
    check("R1 addr load", 32'(dmaAddr), 32'h100);
    check("R1 remain load", 32'(dmaRemain), 16);
    sendByte(8'h11); sendByte(8'h22);
    check("R2 rxLen running", 32'(rxLen), 2);
    check("R2 addr running", 32'(dmaAddr), 32'h102);
    check("R2 remain running", 32'(dmaRemain), 14);
    pushWr(16'h0100, 32'h44332211, 4'hF);
    sendByte(8'h33); sendByte(8'h44);
    sendByte(8'h55); sendByte(8'h66);
    pushWr(16'h0104, 32'h00006655, 4'h3);
    stopXfer();
    check("R5 status group", 32'(status), 32'h0F);
    check("R2 rxLen final", 32'(rxLen), 6);
    tick();
    check("R9 irq raised", 32'(irqOut), 1);
    clearWrite(5'h08);
    check("R7 done clears group", 32'(status), 32'h0);
    check("R9 irq not yet low", 32'(irqOut), 1);
    tick();
    check("R9 irq low after clear", 32'(irqOut), 0);

    // a new matching start resets length before data
    startXfer(7'h2A, 0);
    check("R1 rxLen reset on new start", 32'(rxLen), 0);
    stopXfer();
    clearWrite(5'h08);

    // non-matching transfers
    startXfer(7'h2B, 0); sendByte(8'hEE); stopXfer();
    check("R8 addr mismatch status", 32'(status), 0);
    check("R8 addr mismatch rxLen", 32'(rxLen), 0);
    check("R8 addr mismatch addr", 32'(dmaAddr), 32'h100);
    startXfer(7'h2A, 1); sendByte(8'hEE); stopXfer();
    check("R8 read dir status", 32'(status), 0);
    check("R8 read dir remain", 32'(dmaRemain), 16);
    cfgRxDmaEn = 0;
    startXfer(7'h2A, 0); sendByte(8'hEE); stopXfer();
    check("R8 dma disabled status", 32'(status), 0);
    check("R8 dma disabled addr", 32'(dmaAddr), 32'h100);
    cfgRxDmaEn = 1;
    tick();
    check("R8 irq quiet", 32'(irqOut), 0);

    // overflow with unaligned base
    cfgBufBase = 16'h0203; cfgBufLen = 13'd3;
    startXfer(7'h2A, 0);
    check("R1 base aligned", 32'(dmaAddr), 32'h200);
    sendByte(8'hA1); sendByte(8'hA2); sendByte(8'hA3);
    check("R6 no ovf yet", 32'(status), 0);
    sendByte(8'hA4);
    check("R6 ovf flag", 32'(status), 32'h10);
    check("R6 addr stalled", 32'(dmaAddr), 32'h203);
    sendByte(8'hA5);
    pushWr(16'h0200, 32'h00A3A2A1, 4'h7);
    stopXfer();
    check("R6 done after ovf", 32'(status), 32'h1F);
    check("R6 rxLen capped", 32'(rxLen), 3);
    clearWrite(5'h08);
    check("R7 ovf kept", 32'(status), 32'h10);
    clearWrite(5'h10);
    check("R7 ovf cleared", 32'(status), 0);
    tick(); tick();
    check("R9 irq low", 32'(irqOut), 0);

    // length clamp
    cfgBufBase = 16'h0400; cfgBufLen = 13'd5000;
    startXfer(7'h2A, 0);
    check("R1 length clamp", 32'(dmaRemain), 4096);
    stopXfer();
    check("R4 empty word no write status", 32'(status), 32'h0F);
    clearWrite(5'h08);
    tick(); tick();

    // shared line: host first, target pending
    cfgBufBase = 16'h0300; cfgBufLen = 13'd16;
    hostIrqReq = 1;
    tick(); tick();
    check("R10 host holds", 32'(irqOut), 1);
    startXfer(7'h2A, 0);
    pushWr(16'h0300, 32'hD4C3B2A1, 4'hF);
    sendByte(8'hA1); sendByte(8'hB2); sendByte(8'hC3); sendByte(8'hD4);
    stopXfer();
    tick();
    check("R10 line still high", 32'(irqOut), 1);
    hostIrqReq = 0;
    tick();
    check("R10 gap after host", 32'(irqOut), 0);
    tick();
    check("R10 target re-raised", 32'(irqOut), 1);
    // reverse: target holds, host pending
    hostIrqReq = 1;
    clearWrite(5'h08);
    check("R10 target still holds", 32'(irqOut), 1);
    tick();
    check("R10 gap after target", 32'(irqOut), 0);
    tick();
    check("R10 host re-raised", 32'(irqOut), 1);
    hostIrqReq = 0;
    tick(); tick();
    check("R10 line idle", 32'(irqOut), 0);

    tick();
    check("R3 all writes seen", expQ.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule